// File: doc/BRIEF.md
# Reversible Staged Barrel Rotator

This block rotates an n-bit word to the right by a k-bit amount, where n is a power of two and k = log2(n). The rotation is built from a cascade of k conservative controlled-permutation gates. Gate j (counting from 0) has one control bit and n data bits. Bit j of the amount drives its control. When that bit is 1 the gate rotates its data right by 2^j places. When it is 0 the gate passes its data through unchanged. Each gate forwards its control bit as an extra output. The chain therefore needs no constant inputs and leaves no unused outputs. The number of ones is preserved at every gate.

Both the rotated word and the amount bits are outputs. The complete mapping from (word, amount) to (rotated word, amount) is a bijection, so the original word can always be recovered by rotating left by the forwarded amount. In line with the house FPGA convention, the result of the cascade is captured in one output register that a synchronous active-high reset clears. Results therefore appear one clock after the inputs.

Top module: `rev_barrel_rotator`

## Requirements
- R1: While `rst` is high at a rising clock edge, `word_o` and `amt_o` become all zeros at that edge.
- R2: One clock after inputs are applied (with `rst` low), output bit i of `word_o` equals input bit (i + amt) mod WIDTH of `data_i`. Bit 0 is the least significant bit, and amt is `amt_i` read as an unsigned binary number.
- R3: One clock after inputs are applied, `amt_o` equals `amt_i` unchanged.
- R4: The number of ones in `word_o` equals the number of ones in the `data_i` value it was computed from.
- R5: An amount of zero delivers `data_i` to `word_o` unchanged.
- R6: Amount bit j alone (amount = 2^j) rotates the word right by exactly 2^j places. Stage j reacts only to bit j, so the effects of the bits add up.
- R7: The mapping can be reversed: rotating `word_o` left by `amt_o` places gives back the applied `data_i` for every input combination.
- R8: WIDTH is a power of two, at least 2. The amount width is log2(WIDTH).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; outputs update on its rising edge |
| rst | input | 1 | Synchronous active-high reset; clears the outputs |
| data_i | input | WIDTH | Word to be rotated |
| amt_i | input | log2(WIDTH) | Right-rotation amount; bit j controls stage j |
| word_o | output | WIDTH | Registered rotated word |
| amt_o | output | log2(WIDTH) | Registered copy of the rotation amount |

## Verification
On every clock cycle the bound checker verifies the following properties: the forwarded amount, the preserved count of ones, the rotation against a double-word shift formula, the pass-through at amount zero, and the cleared outputs after reset. Other properties can only be shown by the bench's scenarios. These are reversibility over the whole input space, the per-stage behaviour seen through single-bit amounts, and the exhaustive sweeps at widths 4 and 8. The bench covers every data value and every amount at both widths.

// File: rtl/rot_pkg.sv
package rot_pkg;
  // true when v is a power of two of at least 2
  function automatic bit width_ok(input int v);
    return (v >= 2) && ((v & (v - 1)) == 0);
  endfunction
endpackage

// File: rtl/rot_stage.sv
// One conservative controlled-permutation gate: control bit forwarded,
// data rotated right by STEP when the control is set.
module rot_stage #(
  parameter int WIDTH = 8,
  parameter int STEP  = 1
) (
  input  logic             ctl_i,
  input  logic [WIDTH-1:0] data_i,
  output logic             ctl_o,
  output logic [WIDTH-1:0] data_o
);
  assign ctl_o = ctl_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    localparam int SRC = (i + STEP) % WIDTH;
    assign data_o[i] = ctl_i ? data_i[SRC] : data_i[i];
  end
endmodule

// File: rtl/rot_cascade.sv
// Chain of log2(WIDTH) gates; stage j is driven by amount bit j.
module rot_cascade #(
  parameter int WIDTH = 8,
  localparam int SHW  = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [SHW-1:0]   amt_i,
  output logic [WIDTH-1:0] data_o,
  output logic [SHW-1:0]   amt_o
);
  logic [WIDTH-1:0] link [SHW+1];

  assign link[0] = data_i;

  for (genvar j = 0; j < SHW; j++) begin : g_stage
    rot_stage #(
      .WIDTH (WIDTH),
      .STEP  (1 << j)
    ) u_stage (
      .ctl_i  (amt_i[j]),
      .data_i (link[j]),
      .ctl_o  (amt_o[j]),
      .data_o (link[j+1])
    );
  end

  assign data_o = link[SHW];
endmodule

// File: rtl/rot_oreg.sv
// Output register with synchronous active-high clear.
module rot_oreg #(
  parameter int WIDTH = 8,
  localparam int SHW  = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] word_d,
  input  logic [SHW-1:0]   amt_d,
  output logic [WIDTH-1:0] word_q,
  output logic [SHW-1:0]   amt_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      amt_q  <= '0;
    end else begin
      word_q <= word_d;
      amt_q  <= amt_d;
    end
  end
endmodule

// File: rtl/rev_barrel_rotator.sv
module rev_barrel_rotator #(
  parameter int WIDTH = 8,
  localparam int SHW  = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] data_i,
  input  logic [SHW-1:0]   amt_i,
  output logic [WIDTH-1:0] word_o,
  output logic [SHW-1:0]   amt_o
);
  import rot_pkg::*;

  // R8: elaboration-time legality of the width
  if (!width_ok(WIDTH)) begin : g_bad_width
    $error("rev_barrel_rotator: WIDTH must be a power of two >= 2");
  end

  logic [WIDTH-1:0] rot_word;
  logic [SHW-1:0]   rot_amt;

  rot_cascade #(.WIDTH(WIDTH)) u_cascade (
    .data_i (data_i),
    .amt_i  (amt_i),
    .data_o (rot_word),
    .amt_o  (rot_amt)
  );

  rot_oreg #(.WIDTH(WIDTH)) u_oreg (
    .clk    (clk),
    .rst    (rst),
    .word_d (rot_word),
    .amt_d  (rot_amt),
    .word_q (word_o),
    .amt_q  (amt_o)
  );
endmodule

// File: rtl/rev_barrel_rotator_chk.sv
module rev_barrel_rotator_chk #(
  parameter int WIDTH = 8,
  localparam int SHW  = $clog2(WIDTH)
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] data_i,
  input logic [SHW-1:0]   amt_i,
  input logic [WIDTH-1:0] word_o,
  input logic [SHW-1:0]   amt_o
);
  // independent formula: shift a doubled word right, keep the low half
  function automatic logic [WIDTH-1:0] dbl_rot(input logic [WIDTH-1:0] d,
                                               input logic [SHW-1:0] s);
    logic [2*WIDTH-1:0] w;
    w = {d, d} >> s;
    return w[WIDTH-1:0];
  endfunction

  // R1: cleared after a reset edge
  a_r1_reset_clear: assert property (@(posedge clk)
    $past(rst) === 1'b1 |-> (word_o == '0 && amt_o == '0));

  // R3: amount forwarded untouched
  a_r3_amt_fwd: assert property (@(posedge clk) disable iff (rst)
    $past(rst) === 1'b0 |-> amt_o == $past(amt_i));

  // R4: ones count kept
  a_r4_ones_kept: assert property (@(posedge clk) disable iff (rst)
    $past(rst) === 1'b0 |-> $countones(word_o) == $countones($past(data_i)));

  // R2: rotation matches doubled-word formula
  a_r2_rotate: assert property (@(posedge clk) disable iff (rst)
    $past(rst) === 1'b0 |-> word_o == dbl_rot($past(data_i), $past(amt_i)));

  // R5: zero amount is a pass-through
  a_r5_zero_pass: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) === 1'b0 && $past(amt_i) == '0) |-> word_o == $past(data_i));
endmodule

bind rev_barrel_rotator rev_barrel_rotator_chk #(.WIDTH(WIDTH)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .data_i (data_i),
  .amt_i  (amt_i),
  .word_o (word_o),
  .amt_o  (amt_o)
);

// File: tb/rev_barrel_rotator_tb.sv
`timescale 1ns/1ps
module rev_barrel_rotator_tb;
  typedef struct {
    bit       w4;
    bit [7:0] data;
    bit [2:0] amt;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [7:0] d8 = '0;
  logic [2:0] s8 = '0;
  logic [7:0] q8;
  logic [2:0] a8;
  logic [3:0] d4 = '0;
  logic [1:0] s4 = '0;
  logic [3:0] q4;
  logic [1:0] a4;

  rev_barrel_rotator #(.WIDTH(8)) u_dut (
    .clk(clk), .rst(rst), .data_i(d8), .amt_i(s8), .word_o(q8), .amt_o(a8));
  rev_barrel_rotator #(.WIDTH(4)) u_dut_w4 (
    .clk(clk), .rst(rst), .data_i(d4), .amt_i(s4), .word_o(q4), .amt_o(a4));

  item_t sb[$];
  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  // reference: out bit i = in bit (i+s) mod w
  function automatic bit [7:0] ref_rot(bit [7:0] d, int s, int w);
    bit [7:0] r = '0;
    for (int i = 0; i < w; i++) r[i] = d[(i + s) % w];
    return r;
  endfunction

  task automatic chk(string req, int got, int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s got %0h exp %0h", req, got, exp);
    end
  endtask

  task automatic drive(bit w4, bit [7:0] d, bit [2:0] s);
    item_t it;
    @(negedge clk);
    if (w4) begin d4 = d[3:0]; s4 = s[1:0]; end
    else    begin d8 = d;      s8 = s;      end
    it.w4 = w4; it.data = d; it.amt = s;
    sb.push_back(it);
  endtask

  // monitor: results visible just after the edge following the drive
  initial begin
    forever begin
      @(posedge clk); #1;
      if (sb.size() > 0) begin
        item_t it = sb.pop_front();
        int w = it.w4 ? 4 : 8;
        bit [7:0] got = it.w4 ? {4'h0, q4} : q8;
        int ga = it.w4 ? int'(a4) : int'(a8);
        bit [7:0] exp = ref_rot(it.data, it.amt, w);
        chk("R2 rotate", got, exp);
        chk("R3 amount forwarded", ga, it.amt);
        chk("R4 ones kept", $countones(got), $countones(it.data));
        chk("R7 reversible", ref_rot(got, (w - ga) % w, w), it.data);
        if (it.amt == 0) chk("R5 zero pass", got, it.data);
        if ($countones(it.amt) == 1) chk("R6 single stage", got, ref_rot(it.data, it.amt, w));
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset clears despite nonzero inputs
    @(negedge clk); d8 = 8'hA5; s8 = 3'd5; d4 = 4'hB; s4 = 2'd3;
    @(posedge clk); #1;
    chk("R1 reset word8", q8, 0);
    chk("R1 reset amt8", a8, 0);
    chk("R1 reset word4", q4, 0);
    chk("R1 reset amt4", a4, 0);
    @(negedge clk); rst = 1'b0;
    // R8: exhaustive at both legal widths 4 and 8
    for (int d = 0; d < 16; d++)
      for (int s = 0; s < 4; s++) drive(1'b1, 8'(d), 3'(s));
    for (int d = 0; d < 256; d++)
      for (int s = 0; s < 8; s++) drive(1'b0, 8'(d), 3'(s));
    // R6: stage bits combine additively (1+2+4 = 7)
    drive(1'b0, 8'h01, 3'd7);
    @(negedge clk); @(negedge clk);
    // R1: reset mid-run clears outputs again
    rst = 1'b1;
    @(posedge clk); #1;
    chk("R1 reset again word8", q8, 0);
    chk("R1 reset again amt8", a8, 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule